// File: doc/BRIEF.md
# Control-Register Port Write Master

This block performs one write into the internal configuration space of a PHY. The PHY exposes that space through a narrow parallel port. The port has a control word driven toward the PHY and a status word coming back, and its only flow control is a single acknowledge line. A write takes three handshakes in a fixed order. The first captures the register address, the second captures the data value, and the third commits the data into the register. Each handshake is a four-phase request/acknowledge exchange. The command bit is raised together with the value, the master waits for acknowledge to rise, drops the command bit while holding the value, and then waits for acknowledge to fall.

Every wait is polled on a slow tick that a parameterised divider derives from the system clock. The default gives one poll per microsecond at 250 MHz. A wait gives up after a bounded number of polls. If a wait gives up, the whole write stops at once and is reported as failed. The acknowledge line passes through a two-flop synchroniser before the master uses it. A client starts a write with a request pulse while the block is idle. The client then sees busy for the duration of the write and a one-cycle done pulse, with the error flag valid in that same cycle.

Top module: `crp_wr_master`

## Requirements
- R1: The control word carries the 16-bit value in bits [17:2]. Capture-address is bit 0, capture-data is bit 1 and write-commit is bit 19. At most one of these is set at a time. Bit 18 (read) and bits [31:20] are always 0.
- R2: Before each handshake, the value is presented for at least one cycle with every command bit clear.
- R3: A handshake holds its command bit and value until the acknowledge (status bit 0) is seen high. It then clears the command bit, keeps the same value, and waits for the acknowledge to be seen low.
- R4: A successful write issues exactly three handshakes: the address with capture-address, then the data with capture-data, then the same data with write-commit.
- R5: Acknowledge is polled once every TICK_DIV cycles, at most MAX_POLLS times per wait. If the rising wait runs out, the write fails about MAX_POLLS*TICK_DIV cycles after that wait begins. An acknowledge that arrives well inside the window lets the write proceed.
- R6: Running out of polls while waiting for the acknowledge to fall is also a failure.
- R7: After a failure, no further handshake is started and the control word returns to all zeros.
- R8: done_o is high for exactly one cycle per write, and err_o is valid in that cycle (1 for failure, 0 for success). busy_o is high from the cycle after acceptance until completion and is low in the done cycle.
- R9: A request is accepted only while idle. A request raised while busy has no effect on the write in progress, and no extra write follows.
- R10: After reset, the control word is zero and busy_o, done_o and err_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start a write (taken only while idle) |
| addr_i | input | 16 | Register address inside the PHY |
| data_i | input | 16 | Value to write |
| busy_o | output | 1 | Write in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Completion status, valid with done_o |
| ctrl_o | output | 32 | Control word toward the PHY port |
| stat_i | input | 32 | Status word from the PHY port (bit 0 acknowledge) |

## Verification
A behavioural PHY responder logs every handshake and answers after a programmable delay. It can also leave acknowledge stuck low or stuck high in a chosen phase. The bench drives acknowledges close to the poll budget and far past it. A design with a wrong poll count or tick spacing would then fail a write that should pass, or pass one that should time out, and the timeout latency is measured directly. Stuck acknowledges in the middle and last phases would expose a design that keeps issuing handshakes after a failure, or that ignores the falling-edge timeout. A request raised mid-write would expose a design that restarts or re-latches its operands while busy.

// File: rtl/crp_pkg.sv
package crp_pkg;

  localparam int CW_W    = 32;
  localparam int ST_W    = 32;
  localparam int DATA_W  = 16;
  localparam int DIN_LSB = 2;
  localparam int BIT_CAPA = 0;
  localparam int BIT_CAPD = 1;
  localparam int BIT_RD   = 18;
  localparam int BIT_WR   = 19;
  localparam int ACK_BIT  = 0;

  typedef enum logic [1:0] {PH_ADDR, PH_DATA, PH_COMMIT} phase_e;
  typedef enum logic [1:0] {HS_IDLE, HS_PRE, HS_RISE, HS_FALL} hs_state_e;
  typedef enum logic {TOP_IDLE, TOP_RUN} top_state_e;

  function automatic logic [CW_W-1:0] place_val(input logic [DATA_W-1:0] v);
    logic [CW_W-1:0] w;
    w = '0;
    w[DIN_LSB +: DATA_W] = v;
    return w;
  endfunction

endpackage

// File: rtl/crp_sync2.sv
module crp_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/crp_tick_gen.sv
module crp_tick_gen #(
  parameter int DIV = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (cnt_q == LAST);

  always_comb begin
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/crp_hs_engine.sv
module crp_hs_engine
  import crp_pkg::*;
#(
  parameter int MAX_POLLS = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  phase_e            phase_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic              ack_i,
  input  logic              tick_i,
  output logic              run_o,
  output logic              ok_o,
  output logic              fail_o,
  output logic [CW_W-1:0]   ctrl_o
);
  localparam int PW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam logic [PW-1:0] LAST_POLL = PW'(MAX_POLLS - 1);

  hs_state_e         state_q, state_d;
  phase_e            phase_q, phase_d;
  logic [DATA_W-1:0] val_q, val_d;
  logic [PW-1:0]     polls_q, polls_d;
  logic [CW_W-1:0]   ctrl_q, ctrl_d;

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    val_d   = val_q;
    polls_d = polls_q;
    ok_o    = 1'b0;
    fail_o  = 1'b0;
    case (state_q)
      HS_IDLE: begin
        if (start_i) begin
          val_d   = val_i;
          phase_d = phase_i;
          polls_d = '0;
          state_d = HS_PRE;
        end
      end
      HS_PRE: state_d = HS_RISE;
      HS_RISE: begin
        if (tick_i) begin
          if (ack_i) begin
            polls_d = '0;
            state_d = HS_FALL;
          end else if (polls_q == LAST_POLL) begin
            fail_o  = 1'b1;
            state_d = HS_IDLE;
          end else begin
            polls_d = polls_q + 1'b1;
          end
        end
      end
      HS_FALL: begin
        if (tick_i) begin
          if (!ack_i) begin
            ok_o    = 1'b1;
            state_d = HS_IDLE;
          end else if (polls_q == LAST_POLL) begin
            fail_o  = 1'b1;
            state_d = HS_IDLE;
          end else begin
            polls_d = polls_q + 1'b1;
          end
        end
      end
      default: state_d = HS_IDLE;
    endcase
  end

  always_comb begin
    ctrl_d = '0;
    case (state_d)
      HS_PRE, HS_FALL: ctrl_d = place_val(val_d);
      HS_RISE: begin
        ctrl_d = place_val(val_d);
        case (phase_d)
          PH_ADDR:   ctrl_d[BIT_CAPA] = 1'b1;
          PH_DATA:   ctrl_d[BIT_CAPD] = 1'b1;
          default:   ctrl_d[BIT_WR]   = 1'b1;
        endcase
      end
      default: ctrl_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      phase_q <= PH_ADDR;
      val_q   <= '0;
      polls_q <= '0;
      ctrl_q  <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      val_q   <= val_d;
      polls_q <= polls_d;
      ctrl_q  <= ctrl_d;
    end
  end

  assign run_o  = (state_q == HS_RISE) || (state_q == HS_FALL);
  assign ctrl_o = ctrl_q;

  logic cmd_any;
  assign cmd_any = ctrl_q[BIT_CAPA] | ctrl_q[BIT_CAPD] | ctrl_q[BIT_WR];

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_q[BIT_WR], ctrl_q[BIT_CAPD], ctrl_q[BIT_CAPA]}) && !ctrl_q[BIT_RD]); // R1
  AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_any && !$past(cmd_any)) |-> ($past(ctrl_q[DIN_LSB +: DATA_W]) == ctrl_q[DIN_LSB +: DATA_W])); // R2
  AST_FALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cmd_any) && state_q == HS_FALL) |-> $stable(ctrl_q[DIN_LSB +: DATA_W])); // R3
  AST_RISE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_FALL && $past(state_q) == HS_RISE) |-> $past(ack_i)); // R3
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    polls_q <= LAST_POLL); // R5
  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (state_q == HS_IDLE)); // R9
endmodule

// File: rtl/crp_wr_master.sv
module crp_wr_master
  import crp_pkg::*;
#(
  parameter int TICK_DIV  = 250,
  parameter int MAX_POLLS = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [CW_W-1:0]   ctrl_o,
  input  logic [ST_W-1:0]   stat_i
);
  top_state_e        state_q, state_d;
  phase_e            phase_q, phase_d;
  logic [DATA_W-1:0] addr_q, addr_d, data_q, data_d;
  logic              start_q, start_d;
  logic              done_q, done_d, err_q, err_d;

  logic ack_s, tick, run, eng_ok, eng_fail;
  logic [DATA_W-1:0] eng_val;
  logic unused_stat;

  assign unused_stat = ^stat_i[ST_W-1:ACK_BIT+1];

  crp_sync2 u_ack_sync (
    .clk (clk), .rst_n (rst_n), .d_i (stat_i[ACK_BIT]), .q_o (ack_s)
  );

  crp_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk (clk), .rst_n (rst_n), .run_i (run), .tick_o (tick)
  );

  assign eng_val = (phase_q == PH_ADDR) ? addr_q : data_q;

  crp_hs_engine #(.MAX_POLLS(MAX_POLLS)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_q),
    .phase_i (phase_q),
    .val_i   (eng_val),
    .ack_i   (ack_s),
    .tick_i  (tick),
    .run_o   (run),
    .ok_o    (eng_ok),
    .fail_o  (eng_fail),
    .ctrl_o  (ctrl_o)
  );

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    addr_d  = addr_q;
    data_d  = data_q;
    start_d = 1'b0;
    done_d  = 1'b0;
    err_d   = err_q;
    case (state_q)
      TOP_IDLE: begin
        if (req_i) begin
          addr_d  = addr_i;
          data_d  = data_i;
          phase_d = PH_ADDR;
          start_d = 1'b1;
          state_d = TOP_RUN;
        end
      end
      TOP_RUN: begin
        if (eng_fail) begin
          done_d  = 1'b1;
          err_d   = 1'b1;
          state_d = TOP_IDLE;
        end else if (eng_ok) begin
          if (phase_q == PH_COMMIT) begin
            done_d  = 1'b1;
            err_d   = 1'b0;
            state_d = TOP_IDLE;
          end else begin
            phase_d = (phase_q == PH_ADDR) ? PH_DATA : PH_COMMIT;
            start_d = 1'b1;
          end
        end
      end
      default: state_d = TOP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TOP_IDLE;
      phase_q <= PH_ADDR;
      addr_q  <= '0;
      data_q  <= '0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      start_q <= start_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign busy_o = (state_q == TOP_RUN);
  assign done_o = done_q;
  assign err_o  = err_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R8
  AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o) |-> (ctrl_o == '0)); // R7
  AST_RUN_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> busy_o); // R9
endmodule

// File: tb/crp_wr_master_tb.sv
module crp_wr_master_tb;
  localparam int DIV   = 4;
  localparam int POLLS = 100;
  localparam int LIMIT = DIV * POLLS;
  localparam int NV    = 10;

  // vector: {addr[45:30], data[29:14], dly[13:4], kind[3:2], phase[1:0]}
  // kind: 0 none, 1 ack stuck low, 2 ack stuck high
  localparam logic [45:0] VEC [NV] = '{
    {16'h0015, 16'hA109, 10'd0,   2'd0, 2'd0},
    {16'h0012, 16'hA000, 10'd1,   2'd0, 2'd0},
    {16'h1010, 16'h0080, 10'd7,   2'd0, 2'd0},
    {16'hFFFF, 16'h0000, 10'd30,  2'd0, 2'd0},
    {16'h0000, 16'hFFFF, 10'd388, 2'd0, 2'd0},
    {16'h1234, 16'h5678, 10'd2,   2'd1, 2'd1},
    {16'h4321, 16'h8765, 10'd3,   2'd2, 2'd2},
    {16'h0F0F, 16'hF0F0, 10'd3,   2'd1, 2'd2},
    {16'hAAAA, 16'h5555, 10'd410, 2'd0, 2'd0},
    {16'h5A5A, 16'hA5A5, 10'd2,   2'd2, 2'd0}
  };

  logic        clk, rst_n, req;
  logic [15:0] addr, data;
  logic        busy, done, err;
  logic [31:0] ctrl, stat;
  logic        ack;

  int checks = 0, fails = 0;

  crp_wr_master #(.TICK_DIV(DIV), .MAX_POLLS(POLLS)) u_dut (
    .clk (clk), .rst_n (rst_n), .req_i (req), .addr_i (addr), .data_i (data),
    .busy_o (busy), .done_o (done), .err_o (err), .ctrl_o (ctrl), .stat_i (stat)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign stat = {31'h2D5A_3C1E, ack};

  // responder
  int          rs, cnt, idx, log_n;
  int          pre_viol, fall_viol, bit_viol;
  int          f_kind, f_phase, dly;
  logic [1:0]  log_code [8];
  logic [15:0] log_val  [8];
  logic [31:0] prev, held;

  function automatic logic cmd_any(input logic [31:0] w);
    return w[0] | w[1] | w[19];
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      rs = 0; ack = 1'b0; cnt = 0; prev = '0;
    end else begin
      if (ctrl[18] || (ctrl[31:20] != 0)) bit_viol++;
      case (rs)
        0: if (cmd_any(ctrl)) begin
             idx = log_n;
             if (idx < 8) begin
               log_val[idx]  = ctrl[17:2];
               log_code[idx] = ({ctrl[19], ctrl[1], ctrl[0]} == 3'b001) ? 2'd0 :
                               ({ctrl[19], ctrl[1], ctrl[0]} == 3'b010) ? 2'd1 :
                               ({ctrl[19], ctrl[1], ctrl[0]} == 3'b100) ? 2'd2 : 2'd3;
             end
             log_n++;
             if (cmd_any(prev) || prev[17:2] != ctrl[17:2]) pre_viol++;
             held = ctrl;
             if (f_kind == 1 && f_phase == idx) rs = 5;
             else begin cnt = dly; rs = 1; end
           end
        1: if (cnt == 0) begin ack = 1'b1; rs = 2; end else cnt--;
        2: if (!cmd_any(ctrl)) begin
             if (busy && ctrl[17:2] != held[17:2]) fall_viol++;
             if (f_kind == 2 && f_phase == idx) rs = 4;
             else begin cnt = dly; rs = 3; end
           end
        3: if (cnt == 0) begin ack = 1'b0; rs = 0; end else cnt--;
        4: if (!busy) begin ack = 1'b0; rs = 0; end
        5: if (!cmd_any(ctrl)) rs = 0;
        default: rs = 0;
      endcase
      prev = ctrl;
    end
  end

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // run one write; intrude raises a foreign request mid-write
  task automatic run_txn(input logic [15:0] a, input logic [15:0] d,
                         input bit intrude, output int lat);
    log_n = 0;
    @(negedge clk); req = 1'b1; addr = a; data = d;
    @(negedge clk); req = 1'b0; addr = 16'h0; data = 16'h0;
    lat = 1;
    chk(busy === 1'b1, "R8 busy after accept", busy, 1);
    while (!done) begin
      @(negedge clk); lat++;
      if (intrude && lat == 10) begin req = 1'b1; addr = 16'hDEAD; data = 16'hBEEF; end
      if (intrude && lat == 13) req = 1'b0;
    end
    req = 1'b0;
  endtask

  initial begin
    int lat;
    int exp_n;
    logic exp_err;
    req = 0; addr = 0; data = 0; rst_n = 0;
    f_kind = 0; f_phase = 0; dly = 0; log_n = 0;
    pre_viol = 0; fall_viol = 0; bit_viol = 0;
    repeat (5) @(negedge clk);
    // R10 reset state
    chk(ctrl == 32'h0, "R10 ctrl in reset", ctrl, 0);
    chk({busy, done, err} == 3'b000, "R10 flags in reset", {busy, done, err}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [15:0] va, vd;
      va = VEC[v][45:30]; vd = VEC[v][29:14];
      dly = int'(VEC[v][13:4]); f_kind = int'(VEC[v][3:2]); f_phase = int'(VEC[v][1:0]);
      exp_err = (f_kind != 0) || (dly >= LIMIT);
      exp_n   = (f_kind != 0) ? f_phase + 1 : ((dly >= LIMIT) ? 1 : 3);
      run_txn(va, vd, 1'b0, lat);
      chk(err == exp_err, $sformatf("R5 R6 err vec %0d", v), err, exp_err);
      chk(busy == 1'b0, "R8 busy low in done cycle", busy, 0);
      chk(log_n == exp_n, $sformatf("R7 R4 handshake count vec %0d", v), log_n, exp_n);
      if (exp_n >= 1) chk(log_code[0] == 0 && log_val[0] == va, "R4 R1 address phase",
                          {log_code[0], log_val[0]}, {2'd0, va});
      if (exp_n >= 2) chk(log_code[1] == 1 && log_val[1] == vd, "R4 R1 data phase",
                          {log_code[1], log_val[1]}, {2'd1, vd});
      if (exp_n >= 3) chk(log_code[2] == 2 && log_val[2] == vd, "R4 R1 commit phase",
                          {log_code[2], log_val[2]}, {2'd2, vd});
      @(negedge clk);
      chk(done == 1'b0, "R8 done single cycle", done, 0);
      chk(ctrl == 32'h0, "R7 ctrl idle after write", ctrl, 0);
      while (rs != 0 || ack) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(log_n == exp_n, "R7 no handshake after completion", log_n, exp_n);
    end

    // R5 rising-wait timeout latency
    dly = 0; f_kind = 1; f_phase = 0;
    run_txn(16'h0101, 16'h0202, 1'b0, lat);
    chk(lat >= LIMIT + 1 && lat <= LIMIT + 5, "R5 timeout latency", lat, LIMIT + 3);
    chk(err == 1'b1, "R5 timeout error", err, 1);
    while (rs != 0 || ack) @(negedge clk);
    repeat (3) @(negedge clk);

    // R6 falling-wait timeout in commit phase
    dly = 1; f_kind = 2; f_phase = 2;
    run_txn(16'h0303, 16'h0404, 1'b0, lat);
    chk(err == 1'b1 && log_n == 3, "R6 fall timeout", {err, 8'(log_n)}, {1'b1, 8'd3});
    while (rs != 0 || ack) @(negedge clk);
    repeat (3) @(negedge clk);

    // R9 request while busy ignored
    dly = 20; f_kind = 0; f_phase = 0;
    run_txn(16'h0707, 16'h0808, 1'b1, lat);
    chk(err == 1'b0 && log_n == 3, "R9 write completes", {err, 8'(log_n)}, {1'b0, 8'd3});
    chk(log_val[0] == 16'h0707 && log_val[2] == 16'h0808, "R9 operands unchanged",
        {log_val[0], log_val[2]}, {16'h0707, 16'h0808});
    while (rs != 0 || ack) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(busy == 1'b0 && log_n == 3, "R9 no extra write", {busy, 8'(log_n)}, {1'b0, 8'd3});

    chk(pre_viol == 0, "R2 value presented with commands clear", pre_viol, 0);
    chk(fall_viol == 0, "R3 value held while command drops", fall_viol, 0);
    chk(bit_viol == 0, "R1 read and upper bits stay zero", bit_viol, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule